// File: doc/BRIEF.md
# Page fault code generator

This block sits beside an address-translation walker and turns its fault outcome into the exception report the core consumes. When the walker ends a lookup with a fault, it pulses a strobe along with one or more cause flags: entry absent, reserved bit set, protection-key denial, or plain protection denial. It also supplies the access context: privilege, access kind, the no-execute and supervisor-execute-protect enables, and the virtual address. The block picks one cause, builds the error code from it and the context, and latches vector 14, the code and the address.

Before a walk starts in 64-bit mode, the core can ask the block to check that the address is canonical. A non-canonical address produces a general-protection report (vector 13, error code 0) in place of a page fault. A report is held until the core acknowledges it.

Top module: `pf_report_gen`

## Requirements
- R1: After reset `rpt_valid` is 0 and `rpt_vector`, `rpt_code` and `rpt_addr` are all zero.
- R2: The base error code depends on the winning cause. Entry absent gives 0. Reserved bit sets bit 3. Protection sets bit 0. Protection key sets bits 5 and 0.
- R3: When several cause flags are asserted in one strobe, the winner is chosen in this order: absent, then reserved, then protection key, then protection.
- R4: `user_mode`=1 sets code bit 2. `acc_kind` 1 (store) sets code bit 1. `acc_kind` is encoded 0 load, 1 store, 2 instruction fetch, and 3 is treated as a load.
- R5: An instruction fetch sets code bit 4 only when `nxe_en` or `smep_en` is 1. Otherwise bit 4 stays 0.
- R6: A protection-key cause on an instruction fetch never produces bit 5. It is reported as a protection fault unless a higher cause wins.
- R7: A page fault report carries `rpt_vector`=14 and `rpt_addr`=`vaddr`. It appears one cycle after the strobe, with `rpt_valid`=1.
- R8: A `chk_valid` pulse with `long_mode`=1 tests the address. Bits 63..47 must be all equal, or bits 63..56 when `five_level`=1. If they are not, the report is vector 13, code 0, address `vaddr`. When `long_mode`=0, the check never faults.
- R9: A held report stays unchanged while `ack` is 0, and strobes in that time are dropped. `ack` alone clears `rpt_valid` in the next cycle. `ack` together with a strobe loads the new report.
- R10: A fault strobe with no cause flag has no effect on the report. A check on a canonical address also has no effect.
- R11: When a failing canonical check and a fault strobe arrive in the same cycle, the general-protection report is the one latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flt_valid | input | 1 | Walker fault strobe |
| cause_absent | input | 1 | Entry not present |
| cause_rsvd | input | 1 | Reserved bit set in an entry |
| cause_prot | input | 1 | Access denied by permissions |
| cause_pkey | input | 1 | Access denied by protection key |
| user_mode | input | 1 | Access made at user privilege |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| nxe_en | input | 1 | No-execute enable |
| smep_en | input | 1 | Supervisor-execute-protect enable |
| chk_valid | input | 1 | Canonical-check request |
| long_mode | input | 1 | 64-bit mode active |
| five_level | input | 1 | Five-level paging active |
| vaddr | input | VA_W | Faulting or checked virtual address |
| ack | input | 1 | Core has taken the report |
| rpt_valid | output | 1 | Report held |
| rpt_vector | output | 8 | Exception vector |
| rpt_code | output | ERR_W | Error code |
| rpt_addr | output | VA_W | Fault address |

## Verification
The hardest case to reach is a set of strobes that overlap with a held report. Examples are a strobe arriving while a report is unacknowledged, an acknowledge in the same cycle as a new strobe, and a failing canonical check coinciding with a fault strobe. The stimulus sets up each of these by leaving a report pending on purpose and then driving the coinciding inputs within one cycle. An exhaustive sweep covers every cause mix, access kind, privilege and enable pair, so that the priority rule and the fetch-bit rule are checked together.

// File: rtl/pfr_pkg.sv
package pfr_pkg;
    localparam int VEC_W = 8;
    localparam logic [VEC_W-1:0] VEC_PF = 8'd14;
    localparam logic [VEC_W-1:0] VEC_GP = 8'd13;

    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    localparam int BIT_P    = 0;
    localparam int BIT_W    = 1;
    localparam int BIT_U    = 2;
    localparam int BIT_RSVD = 3;
    localparam int BIT_ID   = 4;
    localparam int BIT_PK   = 5;

    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_ABSENT,
        WIN_RSVD,
        WIN_PKEY,
        WIN_PROT
    } win_e;
endpackage

// File: rtl/pfr_canon.sv
module pfr_canon #(
    parameter int VA_W   = 64,
    parameter int SHIFT4 = 47,
    parameter int SHIFT5 = 56
) (
    input  logic            long_mode,
    input  logic            five_level,
    input  logic [VA_W-1:0] vaddr,
    output logic            bad
);
    localparam int SH_W = $clog2(VA_W);
    localparam logic [SH_W-1:0] SH4 = SH_W'(SHIFT4);
    localparam logic [SH_W-1:0] SH5 = SH_W'(SHIFT5);

    logic [SH_W-1:0]        sh;
    logic signed [VA_W-1:0] ext;

    always_comb begin
        sh  = five_level ? SH5 : SH4;
        ext = $signed(vaddr) >>> sh;
        bad = long_mode && (ext != '0) && (ext != '1);
    end
endmodule

// File: rtl/pfr_code.sv
module pfr_code
    import pfr_pkg::*;
#(
    parameter int ERR_W = 16
) (
    input  logic             cause_absent,
    input  logic             cause_rsvd,
    input  logic             cause_prot,
    input  logic             cause_pkey,
    input  logic             user_mode,
    input  logic [1:0]       acc_kind,
    input  logic             nxe_en,
    input  logic             smep_en,
    output logic             hit,
    output logic [ERR_W-1:0] code
);
    win_e win;
    logic is_fetch;
    logic pkey_ok;

    always_comb begin
        is_fetch = (acc_kind == ACC_FETCH);
        // a key denial cannot apply to a fetch; it degrades to protection
        pkey_ok  = cause_pkey && !is_fetch;
        if (cause_absent)                  win = WIN_ABSENT;
        else if (cause_rsvd)               win = WIN_RSVD;
        else if (pkey_ok)                  win = WIN_PKEY;
        else if (cause_prot || cause_pkey) win = WIN_PROT;
        else                               win = WIN_NONE;
        hit = (win != WIN_NONE);

        code = '0;
        unique case (win)
            WIN_RSVD: code[BIT_RSVD] = 1'b1;
            WIN_PKEY: begin
                code[BIT_PK] = 1'b1;
                code[BIT_P]  = 1'b1;
            end
            WIN_PROT: code[BIT_P] = 1'b1;
            default:  ;
        endcase
        if (user_mode)                    code[BIT_U]  = 1'b1;
        if (acc_kind == ACC_STORE)        code[BIT_W]  = 1'b1;
        if (is_fetch && (nxe_en || smep_en)) code[BIT_ID] = 1'b1;
    end
endmodule

// File: rtl/pfr_hold.sv
module pfr_hold
    import pfr_pkg::*;
#(
    parameter int ERR_W = 16,
    parameter int VA_W  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [VEC_W-1:0] new_vec,
    input  logic [ERR_W-1:0] new_code,
    input  logic [VA_W-1:0]  new_addr,
    input  logic             ack,
    output logic             valid,
    output logic [VEC_W-1:0] vec,
    output logic [ERR_W-1:0] code,
    output logic [VA_W-1:0]  addr
);
    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
        logic [ERR_W-1:0] code;
        logic [VA_W-1:0]  addr;
    } rpt_t;

    rpt_t rpt_d, rpt_q;

    always_comb begin
        rpt_d = rpt_q;
        if (!rpt_q.valid || ack) begin
            if (load) begin
                rpt_d.valid = 1'b1;
                rpt_d.vec   = new_vec;
                rpt_d.code  = new_code;
                rpt_d.addr  = new_addr;
            end else if (ack) begin
                rpt_d.valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rpt_q <= '0;
        else        rpt_q <= rpt_d;
    end

    assign valid = rpt_q.valid;
    assign vec   = rpt_q.vec;
    assign code  = rpt_q.code;
    assign addr  = rpt_q.addr;

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_q.valid && !ack) |=> (rpt_q.valid && $stable(rpt_q.code)
                                   && $stable(rpt_q.vec) && $stable(rpt_q.addr)));

    assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_q.valid && ack && !load) |=> !rpt_q.valid);
endmodule

// File: rtl/pf_report_gen.sv
module pf_report_gen
    import pfr_pkg::*;
#(
    parameter int VA_W   = 64,
    parameter int ERR_W  = 16,
    parameter int SHIFT4 = 47,
    parameter int SHIFT5 = 56
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flt_valid,
    input  logic             cause_absent,
    input  logic             cause_rsvd,
    input  logic             cause_prot,
    input  logic             cause_pkey,
    input  logic             user_mode,
    input  logic [1:0]       acc_kind,
    input  logic             nxe_en,
    input  logic             smep_en,
    input  logic             chk_valid,
    input  logic             long_mode,
    input  logic             five_level,
    input  logic [VA_W-1:0]  vaddr,
    input  logic             ack,
    output logic             rpt_valid,
    output logic [7:0]       rpt_vector,
    output logic [ERR_W-1:0] rpt_code,
    output logic [VA_W-1:0]  rpt_addr
);
    logic             canon_bad;
    logic             pf_hit;
    logic [ERR_W-1:0] pf_code;
    logic             gp_take;
    logic             pf_take;
    logic             load;
    logic [VEC_W-1:0] sel_vec;
    logic [ERR_W-1:0] sel_code;

    pfr_canon #(.VA_W(VA_W), .SHIFT4(SHIFT4), .SHIFT5(SHIFT5)) u_canon (
        .long_mode (long_mode),
        .five_level(five_level),
        .vaddr     (vaddr),
        .bad       (canon_bad)
    );

    pfr_code #(.ERR_W(ERR_W)) u_code (
        .cause_absent(cause_absent),
        .cause_rsvd  (cause_rsvd),
        .cause_prot  (cause_prot),
        .cause_pkey  (cause_pkey),
        .user_mode   (user_mode),
        .acc_kind    (acc_kind),
        .nxe_en      (nxe_en),
        .smep_en     (smep_en),
        .hit         (pf_hit),
        .code        (pf_code)
    );

    always_comb begin
        gp_take  = chk_valid && canon_bad;
        pf_take  = flt_valid && pf_hit && !gp_take;
        load     = gp_take || pf_take;
        sel_vec  = gp_take ? VEC_GP : VEC_PF;
        sel_code = gp_take ? '0 : pf_code;
    end

    pfr_hold #(.ERR_W(ERR_W), .VA_W(VA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .new_vec (sel_vec),
        .new_code(sel_code),
        .new_addr(vaddr),
        .ack     (ack),
        .valid   (rpt_valid),
        .vec     (rpt_vector),
        .code    (rpt_code),
        .addr    (rpt_addr)
    );

    assert_pk_no_fetch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && acc_kind == ACC_FETCH) |-> !pf_code[BIT_PK]);

    assert_pk_has_p_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_code[BIT_PK]) |-> rpt_code[BIT_P]);

    assert_id_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && pf_code[BIT_ID]) |-> (nxe_en || smep_en));

    assert_gp_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid && rpt_vector == VEC_GP) |-> (rpt_code == '0));

    assert_gp_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rpt_valid && chk_valid && canon_bad && flt_valid) |=> (rpt_vector == VEC_GP));
endmodule

// File: tb/pf_report_gen_bench.sv
module pf_report_gen_bench;
    localparam int VA_W  = 64;
    localparam int ERR_W = 16;

    logic clk = 0;
    logic rst_n = 0;
    logic flt_valid = 0, cause_absent = 0, cause_rsvd = 0, cause_prot = 0, cause_pkey = 0;
    logic user_mode = 0, nxe_en = 0, smep_en = 0, chk_valid = 0, long_mode = 0, five_level = 0, ack = 0;
    logic [1:0] acc_kind = 0;
    logic [VA_W-1:0] vaddr = 0;
    logic rpt_valid;
    logic [7:0] rpt_vector;
    logic [ERR_W-1:0] rpt_code;
    logic [VA_W-1:0] rpt_addr;

    pf_report_gen u_pf_report_gen (
        .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .cause_absent(cause_absent),
        .cause_rsvd(cause_rsvd), .cause_prot(cause_prot), .cause_pkey(cause_pkey),
        .user_mode(user_mode), .acc_kind(acc_kind), .nxe_en(nxe_en), .smep_en(smep_en),
        .chk_valid(chk_valid), .long_mode(long_mode), .five_level(five_level),
        .vaddr(vaddr), .ack(ack), .rpt_valid(rpt_valid), .rpt_vector(rpt_vector),
        .rpt_code(rpt_code), .rpt_addr(rpt_addr)
    );

    always #10 clk = ~clk;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    string tag = "R1";

    logic m_valid;
    logic [7:0] m_vec;
    logic [ERR_W-1:0] m_code;
    logic [VA_W-1:0] m_addr;

    function automatic bit noncanon(input logic [VA_W-1:0] a, input bit lm, input bit fl);
        int top;
        if (!lm) return 0;
        top = fl ? 56 : 47;
        for (int i = top; i < VA_W; i++) if (a[i] != a[VA_W-1]) return 1;
        return 0;
    endfunction

    // behavioural reference: returns 1 when a page fault is reported
    function automatic bit pf_expect(output logic [ERR_W-1:0] c);
        bit fetch;
        c = 0;
        fetch = (acc_kind == 2);
        if (cause_absent) c = 0;
        else if (cause_rsvd) c = 16'h0008;
        else if (cause_pkey && !fetch) c = 16'h0021;
        else if (cause_prot || cause_pkey) c = 16'h0001;
        else return 0;
        if (user_mode) c = c | 16'h0004;
        if (acc_kind == 1) c = c | 16'h0002;
        if (fetch && (nxe_en || smep_en)) c = c | 16'h0010;
        return 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        logic [ERR_W-1:0] c;
        bit gp, pf;
        if (!rst_n) begin
            m_valid <= 0; m_vec <= 0; m_code <= 0; m_addr <= 0;
        end else begin
            gp = chk_valid && noncanon(vaddr, long_mode, five_level);
            pf = flt_valid && pf_expect(c);
            if (!m_valid || ack) begin
                if (gp) begin
                    m_valid <= 1; m_vec <= 13; m_code <= 0; m_addr <= vaddr;
                end else if (pf) begin
                    m_valid <= 1; m_vec <= 14; m_code <= c; m_addr <= vaddr;
                end else if (ack) m_valid <= 0;
            end
        end
    end

    always @(negedge clk) begin
        cycles++;
        n_cmp++;
        if (rpt_valid !== m_valid || rpt_vector !== m_vec || rpt_code !== m_code || rpt_addr !== m_addr) begin
            n_bad++;
            $display("FAIL %s: got v=%0b vec=%0d code=%h addr=%h exp v=%0b vec=%0d code=%h addr=%h",
                     tag, rpt_valid, rpt_vector, rpt_code, rpt_addr, m_valid, m_vec, m_code, m_addr);
        end
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog: got %0d cycles exp below 100000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic step(); @(negedge clk); endtask

    task automatic idle();
        flt_valid = 0; chk_valid = 0; ack = 0;
        cause_absent = 0; cause_rsvd = 0; cause_prot = 0; cause_pkey = 0;
    endtask

    task automatic fault(input logic [3:0] cz, input logic [1:0] ak, input bit u, input bit nx,
                         input bit sm, input logic [VA_W-1:0] a);
        step();
        flt_valid = 1; {cause_absent, cause_rsvd, cause_pkey, cause_prot} = cz;
        acc_kind = ak; user_mode = u; nxe_en = nx; smep_en = sm; vaddr = a;
        step(); idle();
        step(); ack = 1;
        step(); idle();
    endtask

    task automatic check(input bit lm, input bit fl, input logic [VA_W-1:0] a);
        step();
        chk_valid = 1; long_mode = lm; five_level = fl; vaddr = a;
        step(); idle();
        step(); ack = 1;
        step(); idle();
    endtask

    initial begin
        tag = "R1";
        repeat (3) step();
        rst_n = 1;
        step();

        tag = "R2";
        fault(4'b1000, 0, 0, 0, 0, 64'h1000);
        fault(4'b0100, 0, 0, 0, 0, 64'h2000);
        fault(4'b0001, 0, 0, 0, 0, 64'h3000);
        fault(4'b0010, 0, 0, 0, 0, 64'h4000);
        tag = "R3";
        fault(4'b1111, 1, 1, 0, 0, 64'h5000);
        fault(4'b0111, 0, 0, 0, 0, 64'h5008);
        fault(4'b0011, 1, 0, 0, 0, 64'h5010);
        tag = "R4";
        fault(4'b0001, 1, 1, 0, 0, 64'h6000);
        fault(4'b0001, 3, 1, 0, 0, 64'h6008);
        tag = "R5";
        fault(4'b0001, 2, 0, 0, 0, 64'h7000);
        fault(4'b0001, 2, 0, 1, 0, 64'h7008);
        fault(4'b0001, 2, 1, 0, 1, 64'h7010);
        tag = "R6";
        fault(4'b0010, 2, 1, 1, 1, 64'h8000);
        tag = "R7";
        fault(4'b1000, 0, 0, 0, 0, 64'hdead_beef_0000_1234);

        tag = "R8";
        check(1, 0, 64'h0000_8000_0000_0000);
        check(1, 0, 64'hffff_8000_0000_0000);
        check(1, 1, 64'h0000_8000_0000_0000);
        check(1, 1, 64'h0100_0000_0000_0000);
        check(1, 1, 64'hff80_0000_0000_0000);
        check(0, 0, 64'h1234_0000_0000_0000);
        tag = "R10";
        check(1, 0, 64'h0000_7fff_ffff_f000);
        fault(4'b0000, 1, 1, 1, 1, 64'h9000);

        tag = "R9";
        step(); flt_valid = 1; cause_absent = 1; acc_kind = 0; vaddr = 64'hA000;
        step(); cause_absent = 0; cause_rsvd = 1; vaddr = 64'hB000;
        step(); idle();
        step(); ack = 1; flt_valid = 1; cause_prot = 1; vaddr = 64'hC000;
        step(); idle();
        step(); ack = 1;
        step(); idle();
        step(); ack = 1;
        step(); idle();

        tag = "R11";
        step(); chk_valid = 1; long_mode = 1; five_level = 0; flt_valid = 1; cause_rsvd = 1;
        vaddr = 64'h0001_0000_0000_0000;
        step(); idle();
        step(); ack = 1;
        step(); idle();

        tag = "R2/R3/R4/R5/R6/R7 sweep";
        long_mode = 0;
        for (int cz = 0; cz < 16; cz++)
            for (int ak = 0; ak < 4; ak++)
                for (int m = 0; m < 8; m++)
                    fault(cz[3:0], ak[1:0], m[0], m[1], m[2], 64'(cz * 4096 + ak * 64 + m));

        step(); step();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule